// File: doc/BRIEF.md
# Packed-Pixel Frame Buffer Writer

This block moves finished pixel results into a single-ported 16-bit SRAM that also serves as the display frame buffer. Each memory word carries four 4-bit pixels. A new pixel therefore cannot be written on its own: the block reads the word that holds it, replaces one nibble, and writes the word back. The other three pixels keep their values.

The display scanner owns the SRAM while it paints visible pixels. The writer may touch the memory only while the display is blanking, which covers both the horizontal and the vertical retrace. The timing source gives a blanking flag and a count of the blanking cycles still left, including the current one. The writer starts a read-modify-write only when that count shows the whole sequence fits in the remaining window. Once a sequence starts, it always finishes before the visible area resumes. Results come from a FIFO. The block pops one entry per completed sequence and waits while the FIFO is empty.

With default parameters the frame is 1024 x 768 pixels in a 256K x 16 memory. The row index supplies the upper address bits and the column supplies the rest.

Top module: `pixel_rmw_writer`

## Requirements
- R1: An entry is packed as {in_set[1], iter[ITER_BITS], v[V_BITS], h[H_BITS]} from MSB to LSB. Its word address is {v, h[H_BITS-1:2]}, i.e. v*2^(H_BITS-2) + h/4. The nibble select is h[1:0], and nibble 0 occupies bits [3:0] of the word.
- R2: The stored 4-bit pixel is iter modulo 16, or 0 when in_set is 1.
- R3: The written word equals the word read from the same address, with only the selected nibble replaced.
- R4: mem_rd or mem_wr is high only in cycles where blank is high. disp_grant is low in every cycle in which the writer drives the memory, and high in every other cycle after reset.
- R5: A sequence starts (mem_rd rises in the next cycle) only when, in the deciding cycle, blank is high and blank_left is at least 4. In a blanking window shorter than 4 cycles, no access is made.
- R6: A started sequence always runs to the end. mem_rd is high for one cycle, the read data is taken from mem_rdata in the following cycle, and mem_wr is high for one cycle two cycles after mem_rd. All of these cycles fall inside the same blanking window.
- R7: px_pop pulses for exactly one cycle per sequence, in the same cycle as mem_wr. No sequence starts while px_valid is low.
- R8: While reset is held, and in the first cycle after it, disp_grant is 1 and mem_rd, mem_wr and px_pop are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Pixel FIFO holds at least one entry |
| px_entry | input | ENTRY_W | Head entry of the pixel FIFO |
| px_pop | output | 1 | Removes the head entry at this clock edge |
| blank | input | 1 | Display is in horizontal or vertical blanking |
| blank_left | input | LEFT_BITS | Blanking cycles remaining, current cycle included |
| disp_grant | output | 1 | Display reader may use the SRAM |
| mem_addr | output | ADDR_BITS | SRAM word address |
| mem_rd | output | 1 | SRAM read strobe, data returned next cycle |
| mem_wr | output | 1 | SRAM write strobe |
| mem_wdata | output | WORD_BITS | SRAM write data |
| mem_rdata | input | WORD_BITS | SRAM read data |

## Verification
The bench builds the block with H_BITS=4, V_BITS=3, ITER_BITS=6 and LEFT_BITS=6. This gives a 32-word memory holding 128 pixels, so every pixel position and every nibble lane can be swept. Two full passes run in opposite orders, and the second overwrites the first. Merges are therefore checked against words that already hold live data, and each final word is compared with a value computed from the pixel formula. The small blanking counter lets the bench try windows of 8, 7, 4 and 3 cycles. These cover two sequences per window, one per window, a sequence that starts on the last legal cycle, and a window where nothing may start.

// File: rtl/pxw_pkg.sv
package pxw_pkg;
  // Cycles from the decision cycle to the last bus cycle of a sequence, inclusive.
  localparam int RMW_LEN = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } rmw_state_t;
endpackage

// File: rtl/pxw_unpack.sv
module pxw_unpack #(
  parameter int H_BITS    = 10,
  parameter int V_BITS    = 10,
  parameter int ITER_BITS = 16,
  parameter int PIX_BITS  = 4,
  parameter int SEL_BITS  = 2,
  localparam int ADDR_BITS = V_BITS + H_BITS - SEL_BITS,
  localparam int ENTRY_W   = 1 + ITER_BITS + V_BITS + H_BITS
) (
  input  logic [ENTRY_W-1:0]   entry,
  output logic [ADDR_BITS-1:0] addr,
  output logic [SEL_BITS-1:0]  sel,
  output logic [PIX_BITS-1:0]  pix
);
  logic [H_BITS-1:0]    col;
  logic [V_BITS-1:0]    row;
  logic [ITER_BITS-1:0] iter;
  logic                 in_set;

  assign col    = entry[H_BITS-1:0];
  assign row    = entry[H_BITS +: V_BITS];
  assign iter   = entry[H_BITS+V_BITS +: ITER_BITS];
  assign in_set = entry[ENTRY_W-1];

  // R1: row selects the upper address bits, column/lanes the lower
  assign addr = {row, col[H_BITS-1:SEL_BITS]};
  assign sel  = col[SEL_BITS-1:0];
  // R2: colour index wraps modulo 2^PIX_BITS, members of the set are black
  assign pix  = in_set ? '0 : iter[PIX_BITS-1:0];
endmodule

// File: rtl/pxw_merge.sv
module pxw_merge #(
  parameter int WORD_BITS = 16,
  parameter int PIX_BITS  = 4,
  localparam int LANES    = WORD_BITS / PIX_BITS,
  localparam int SEL_BITS = $clog2(LANES)
) (
  input  logic [WORD_BITS-1:0] old_word,
  input  logic [SEL_BITS-1:0]  sel,
  input  logic [PIX_BITS-1:0]  pix,
  output logic [WORD_BITS-1:0] new_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign new_word[g*PIX_BITS +: PIX_BITS] =
      (sel == SEL_BITS'(g)) ? pix : old_word[g*PIX_BITS +: PIX_BITS];
  end
endmodule

// File: rtl/pxw_seq.sv
module pxw_seq
  import pxw_pkg::*;
#(
  parameter int ADDR_BITS = 18,
  parameter int WORD_BITS = 16,
  parameter int PIX_BITS  = 4,
  parameter int SEL_BITS  = 2,
  parameter int LEFT_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 px_valid,
  input  logic                 blank,
  input  logic [LEFT_BITS-1:0] blank_left,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [SEL_BITS-1:0]  sel_i,
  input  logic [PIX_BITS-1:0]  pix_i,
  input  logic [WORD_BITS-1:0] merged_i,
  output logic [SEL_BITS-1:0]  sel_o,
  output logic [PIX_BITS-1:0]  pix_o,
  output logic                 px_pop,
  output logic                 disp_grant,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [WORD_BITS-1:0] mem_wdata
);
  rmw_state_t state;
  logic       fits;
  logic       start;

  // R5: the whole sequence must fit in the blanking cycles left
  assign fits  = blank && (blank_left >= LEFT_BITS'(RMW_LEN));
  assign start = (state == ST_IDLE) && px_valid && fits;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_addr   <= '0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_wdata  <= '0;
      px_pop     <= 1'b0;
      disp_grant <= 1'b1;
      sel_o      <= '0;
      pix_o      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mem_addr   <= addr_i;
            sel_o      <= sel_i;
            pix_o      <= pix_i;
            mem_rd     <= 1'b1;
            disp_grant <= 1'b0;
            state      <= ST_READ;
          end
        end
        ST_READ: begin
          mem_rd <= 1'b0;
          state  <= ST_MERGE;
        end
        ST_MERGE: begin
          mem_wdata <= merged_i;
          mem_wr    <= 1'b1;
          px_pop    <= 1'b1;
          state     <= ST_WRITE;
        end
        ST_WRITE: begin
          mem_wr     <= 1'b0;
          px_pop     <= 1'b0;
          disp_grant <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  access_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> blank);
  // R4
  grant_released_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> !disp_grant);
  // R5
  start_fits_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> ($past(blank) && ($past(blank_left) >= LEFT_BITS'(RMW_LEN))));
  // R6
  write_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> ##1 mem_wr);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R7
  pop_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    px_pop == mem_wr);
  // R7
  single_pop_chk: assert property (@(posedge clk) disable iff (rst)
    px_pop |=> !px_pop);
  // R7
  start_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> $past(px_valid));
endmodule

// File: rtl/pixel_rmw_writer.sv
module pixel_rmw_writer #(
  parameter int H_BITS    = 10,
  parameter int V_BITS    = 10,
  parameter int ITER_BITS = 16,
  parameter int PIX_BITS  = 4,
  parameter int WORD_BITS = 16,
  parameter int LEFT_BITS = 11,
  localparam int LANES     = WORD_BITS / PIX_BITS,
  localparam int SEL_BITS  = $clog2(LANES),
  localparam int ADDR_BITS = V_BITS + H_BITS - SEL_BITS,
  localparam int ENTRY_W   = 1 + ITER_BITS + V_BITS + H_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 px_valid,
  input  logic [ENTRY_W-1:0]   px_entry,
  output logic                 px_pop,
  input  logic                 blank,
  input  logic [LEFT_BITS-1:0] blank_left,
  output logic                 disp_grant,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [WORD_BITS-1:0] mem_wdata,
  input  logic [WORD_BITS-1:0] mem_rdata
);
  logic [ADDR_BITS-1:0] head_addr;
  logic [SEL_BITS-1:0]  head_sel, lat_sel;
  logic [PIX_BITS-1:0]  head_pix, lat_pix;
  logic [WORD_BITS-1:0] merged;

  pxw_unpack #(
    .H_BITS(H_BITS), .V_BITS(V_BITS), .ITER_BITS(ITER_BITS),
    .PIX_BITS(PIX_BITS), .SEL_BITS(SEL_BITS)
  ) u_unpack (
    .entry(px_entry), .addr(head_addr), .sel(head_sel), .pix(head_pix)
  );

  // R3: lane replace on the word returned by the read
  pxw_merge #(.WORD_BITS(WORD_BITS), .PIX_BITS(PIX_BITS)) u_merge (
    .old_word(mem_rdata), .sel(lat_sel), .pix(lat_pix), .new_word(merged)
  );

  pxw_seq #(
    .ADDR_BITS(ADDR_BITS), .WORD_BITS(WORD_BITS), .PIX_BITS(PIX_BITS),
    .SEL_BITS(SEL_BITS), .LEFT_BITS(LEFT_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .px_valid(px_valid), .blank(blank),
    .blank_left(blank_left), .addr_i(head_addr), .sel_i(head_sel),
    .pix_i(head_pix), .merged_i(merged), .sel_o(lat_sel), .pix_o(lat_pix),
    .px_pop(px_pop), .disp_grant(disp_grant), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/sim_pixel_rmw_writer.sv
module sim_pixel_rmw_writer;
  localparam int H = 4, V = 3, IT = 6, LB = 6;
  localparam int EW = 1 + IT + V + H;
  localparam int AW = V + H - 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          px_valid, px_pop, blank, disp_grant, mem_rd, mem_wr;
  logic [EW-1:0] px_entry;
  logic [LB-1:0] blank_left;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata;

  logic [EW-1:0] fq [0:511];
  int wr_p = 0, rd_p = 0;
  int act_len = 12, blk_len = 8, pos = 0;
  logic restart = 1'b0;
  logic timed_out = 1'b0;
  logic [15:0] mem [0:NW-1];
  logic [15:0] smem [0:NW-1];
  int checks = 0, errs = 0, m_checks = 0, m_errs = 0, acc_cnt = 0;

  assign px_valid   = (rd_p != wr_p);
  assign px_entry   = fq[rd_p % 512];
  assign blank      = (pos >= act_len);
  assign blank_left = blank ? LB'(act_len + blk_len - pos) : '0;

  pixel_rmw_writer #(.H_BITS(H), .V_BITS(V), .ITER_BITS(IT), .LEFT_BITS(LB)) u0 (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_entry(px_entry),
    .px_pop(px_pop), .blank(blank), .blank_left(blank_left),
    .disp_grant(disp_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] init_word(int i);
    return 16'h1234 ^ 16'(i * 16'h0f1d);
  endfunction

  function automatic int iter_of(int pass, int v, int h);
    return ((v * 16 + h) * (pass == 0 ? 5 : 11) + 3 + pass) % 64;
  endfunction

  function automatic bit set_of(int pass, int v, int h);
    return ((h + v + pass) % 7) == 0;
  endfunction

  function automatic logic [3:0] pix_of(int pass, int v, int h);
    return set_of(pass, v, h) ? 4'd0 : 4'(iter_of(pass, v, h) % 16);
  endfunction

  function automatic logic [EW-1:0] mk_entry(int pass, int v, int h);
    return {set_of(pass, v, h), 6'(iter_of(pass, v, h)), 3'(v), 4'(h)};
  endfunction

  // SRAM model: one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (rst || restart) pos <= 0;
    else if (pos >= act_len + blk_len - 1) pos <= 0;
    else pos <= pos + 1;
  end

  always @(posedge clk) if (!rst && px_pop) rd_p <= rd_p + 1;

  task automatic mchk(input bit ok, input string tag, input int act, input int exp);
    m_checks++;
    if (!ok) begin
      m_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Port monitor
  logic rd_d1 = 1'b0, rd_d2 = 1'b0, prev_blank = 1'b0, prev_valid = 1'b0;
  int prev_left = 0;
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) smem[i] = init_word(i);
      rd_d1 = 1'b0; rd_d2 = 1'b0;
    end else begin
      if (mem_rd || mem_wr) begin
        acc_cnt++;
        mchk(blank, "R4 access outside blanking", int'(blank), 1);
      end
      mchk(disp_grant == !(mem_rd || mem_wr || rd_d1), "R4 display grant",
           int'(disp_grant), int'(!(mem_rd || mem_wr || rd_d1)));
      if (mem_rd) begin
        mchk(prev_blank && prev_left >= 4, "R5 start with too few cycles left", prev_left, 4);
        mchk(prev_valid, "R7 start without data", int'(prev_valid), 1);
      end
      if (mem_wr) mchk(rd_d2 && !rd_d1 && !mem_rd, "R6 write two cycles after read",
                       int'({rd_d2, rd_d1}), 2);
      mchk(px_pop == mem_wr, "R7 pop aligned with write", int'(px_pop), int'(mem_wr));
      if (mem_wr) begin
        logic [EW-1:0] e;
        logic [AW-1:0] ea;
        logic [1:0]    es;
        logic [3:0]    ep;
        logic [15:0]   ew;
        e  = fq[rd_p % 512];
        ea = e[H+V-1:2];
        es = e[1:0];
        ep = e[EW-1] ? 4'd0 : e[H+V +: 4];
        ew = smem[ea];
        ew[es*4 +: 4] = ep;
        mchk(mem_addr == ea, "R1 word address", int'(mem_addr), int'(ea));
        mchk(mem_wdata[es*4 +: 4] == ep, "R2 pixel value", int'(mem_wdata[es*4 +: 4]), int'(ep));
        mchk(mem_wdata == ew, "R3 merged word", int'(mem_wdata), int'(ew));
        smem[ea] = ew;
      end
      rd_d2 = rd_d1;
      rd_d1 = mem_rd;
    end
    prev_blank = blank;
    prev_left  = int'(blank_left);
    prev_valid = px_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1'b1;
  end

  task automatic push(input logic [EW-1:0] e);
    fq[wr_p % 512] = e;
    wr_p = wr_p + 1;
  endtask

  task automatic set_line(input int a, input int b);
    @(negedge clk);
    act_len = a; blk_len = b; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic drain();
    while (rd_p != wr_p && !timed_out) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_image(input int pass, input string tag);
    for (int i = 0; i < NW; i++) begin
      logic [15:0] w;
      for (int k = 0; k < 4; k++) w[k*4 +: 4] = pix_of(pass, i >> 2, (i % 4) * 4 + k);
      chk(mem[i] == w, tag, int'(mem[i]), int'(w));
    end
  endtask

  initial begin
    int acc0, rd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(disp_grant && !mem_rd && !mem_wr && !px_pop, "R8 reset outputs",
        int'({disp_grant, mem_rd, mem_wr, px_pop}), 8);
    rst = 1'b0;
    @(negedge clk);
    chk(disp_grant && !mem_rd && !mem_wr && !px_pop, "R8 first cycle after reset",
        int'({disp_grant, mem_rd, mem_wr, px_pop}), 8);

    // R7: empty FIFO, no access at all
    repeat (100) @(negedge clk);
    chk(acc_cnt == 0, "R7 no access while empty", acc_cnt, 0);

    // R1 R2 R3: forward sweep, 8-cycle windows (two sequences each)
    for (int v = 0; v < 8; v++)
      for (int h = 0; h < 16; h++) push(mk_entry(0, v, h));
    drain();
    check_image(0, "R3 image after forward pass");

    // Reverse overwrite, 7-cycle windows (one sequence each)
    set_line(12, 7);
    for (int v = 7; v >= 0; v--)
      for (int h = 15; h >= 0; h--) push(mk_entry(1, v, h));
    drain();
    check_image(1, "R3 image after reverse pass");

    // R5: 3-cycle windows admit nothing
    set_line(12, 3);
    acc0 = acc_cnt; rd0 = rd_p;
    for (int h = 12; h < 16; h++) push(mk_entry(2, 7, h));
    repeat (200) @(negedge clk);
    chk(acc_cnt == acc0, "R5 no access in short window", acc_cnt, acc0);
    chk(rd_p == rd0, "R5 no pop in short window", rd_p, rd0);
    chk(mem[NW-1] == {pix_of(1, 7, 15), pix_of(1, 7, 14), pix_of(1, 7, 13), pix_of(1, 7, 12)},
        "R5 word untouched", int'(mem[NW-1]), 0);

    // R5 R6: 4-cycle windows, start exactly on the last legal cycle
    set_line(12, 4);
    drain();
    chk(rd_p == wr_p, "R5 exact-fit windows drain", rd_p, wr_p);
    chk(mem[NW-1] == {pix_of(2, 7, 15), pix_of(2, 7, 14), pix_of(2, 7, 13), pix_of(2, 7, 12)},
        "R3 exact-fit word", int'(mem[NW-1]), 0);
    chk(mem[NW-2] == {pix_of(1, 7, 11), pix_of(1, 7, 10), pix_of(1, 7, 9), pix_of(1, 7, 8)},
        "R3 neighbour word kept", int'(mem[NW-2]), 0);

    if (timed_out) chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks + m_checks, errs + m_errs);
    $finish;
  end
endmodule